// File: doc/BRIEF.md
# Dual-Mode SIMD Significand Multiplier

This block is the significand multiplier array of a floating-point multiply-add datapath that serves two precisions. A per-transaction mode bit picks one of two uses for the same four lane multipliers. In double mode, four independent pairs of 53-bit significands are multiplied, and four independent 106-bit products come out. In quad mode, one pair of 113-bit significands is cut into a high and a low part each. The four cross products are spread over the four lanes, and then shifted and summed into one exact 226-bit product.

Each lane multiplier is 57 bits wide so that it covers both cases. In double mode the top four bits of each lane operand are zero. In quad mode the high part is bits [112:56] and the low part is bits [55:0], zero-extended to 57 bits. Lane 0 forms low×low, lane 1 high(A)×low(B), lane 2 low(A)×high(B) and lane 3 high×high. The array is a three-stage pipeline: operand registers, lane product registers, and output registers. The mode travels with the data, so the two modes can be mixed cycle by cycle. Exponents, alignment, addition, normalization and rounding belong to the surrounding datapath.

Top module: `simd_sig_mul`

## Requirements
- R1: In double mode (mode_i = 0), for each lane k in 0..3, prod_o[106k+105:106k] equals a_i[53k+52:53k] × b_i[53k+52:53k], with no carry between lanes.
- R2: In quad mode (mode_i = 1), prod_o[225:0] equals a_i[112:0] × b_i[112:0] exactly, and prod_o[423:226] is zero.
- R3: A transaction presented with valid_i = 1 appears on prod_o with valid_o = 1 exactly three clock edges later. valid_o is valid_i delayed by three cycles.
- R4: The mode is held per transaction. Alternating the mode on every cycle gives each transaction the result of its own mode.
- R5: In quad mode, a_i and b_i bits [211:113] are ignored.
- R6: All-ones operands give the exact maximum product in both modes: (2^53−1)^2 per lane, and (2^113−1)^2 for quad.
- R7: While rst_ni is low, valid_o and prod_o are zero.
- R8: A cycle with valid_i = 0 leaves prod_o unchanged at the time that cycle reaches the output, and drives valid_o low.
- R9: A zero operand gives a zero product in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Transaction present |
| mode_i | input | 1 | 0: four double lanes, 1: one quad product |
| a_i | input | 212 | Operand A: four 53-bit lanes, or a 113-bit significand in the low bits |
| b_i | input | 212 | Operand B, same layout as a_i |
| valid_o | output | 1 | Result present |
| prod_o | output | 424 | Four 106-bit lane products, or a 226-bit quad product in the low bits |

## Verification
The critical overlap is a quad transaction in the merge stage while a double transaction sits in the lane multipliers, or the reverse. A wrongly aligned mode flag then applies the shift-and-sum to lane products or packs cross products as lanes. This is provoked by a run that flips mode_i on every cycle, with all-ones and zero operands placed inside the run and some idle cycles mixed in. Each output is compared with a full-width arithmetic product computed in the bench for the mode of its own transaction.

// File: rtl/simd_sig_mul_pkg.sv
package simd_sig_mul_pkg;
  typedef enum logic {
    MODE_DBL  = 1'b0,
    MODE_QUAD = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/sm_operand_route.sv
module sm_operand_route #(
  parameter int LANES  = 4,
  parameter int DBL_W  = 53,
  parameter int QUAD_W = 113,
  parameter int LANE_W = 57,
  parameter int OPND_W = 212
) (
  input  logic                           quad_i,
  input  logic [OPND_W-1:0]              a_i,
  input  logic [OPND_W-1:0]              b_i,
  output logic [LANES-1:0][LANE_W-1:0]   la_o,
  output logic [LANES-1:0][LANE_W-1:0]   lb_o
);
  localparam int LO_W = QUAD_W - LANE_W;

  logic [LANE_W-1:0] ah, al, bh, bl;

  assign ah = a_i[QUAD_W-1:LO_W];
  assign bh = b_i[QUAD_W-1:LO_W];
  assign al = LANE_W'(a_i[LO_W-1:0]);
  assign bl = LANE_W'(b_i[LO_W-1:0]);

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      la_o[k] = LANE_W'(a_i[k*DBL_W +: DBL_W]);
      lb_o[k] = LANE_W'(b_i[k*DBL_W +: DBL_W]);
    end
    if (quad_i) begin
      // lane order fixed by the merge weights: ll, hl, lh, hh
      la_o[0] = al; lb_o[0] = bl;
      la_o[1] = ah; lb_o[1] = bl;
      la_o[2] = al; lb_o[2] = bh;
      la_o[3] = ah; lb_o[3] = bh;
    end
  end
endmodule

// File: rtl/sm_lane_mul.sv
module sm_lane_mul #(
  parameter int DBL_W  = 53,
  parameter int LANE_W = 57
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  dbl_i,
  input  logic [LANE_W-1:0]     a_i,
  input  logic [LANE_W-1:0]     b_i,
  output logic [2*LANE_W-1:0]   p_o
);
  localparam int P_W = 2 * LANE_W;
  localparam int D_W = 2 * DBL_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_o <= '0;
    else if (en_i) p_o <= P_W'(a_i) * P_W'(b_i);
  end

  AST_DBL_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dbl_i) |=> (p_o[P_W-1:D_W] == '0)); // R1
endmodule

// File: rtl/sm_prod_merge.sv
module sm_prod_merge #(
  parameter int LANES  = 4,
  parameter int DBL_W  = 53,
  parameter int QUAD_W = 113,
  parameter int LANE_W = 57,
  parameter int OUT_W  = 424
) (
  input  logic                            quad_i,
  input  logic [LANES-1:0][2*LANE_W-1:0]  p_i,
  output logic [OUT_W-1:0]                r_o
);
  localparam int LO_W = QUAD_W - LANE_W;
  localparam int QP_W = 2 * QUAD_W;
  localparam int D_W  = 2 * DBL_W;

  logic [OUT_W-1:0] dbl_pack;
  logic [QP_W-1:0]  q_hh, q_mid, q_ll, q_sum;

  always_comb begin
    dbl_pack = '0;
    for (int k = 0; k < LANES; k++) dbl_pack[k*D_W +: D_W] = p_i[k][D_W-1:0];
  end

  assign q_ll  = QP_W'(p_i[0]);
  assign q_mid = (QP_W'(p_i[1]) + QP_W'(p_i[2])) << LO_W;
  assign q_hh  = QP_W'(p_i[3]) << (2 * LO_W);
  assign q_sum = q_hh + q_mid + q_ll;

  assign r_o = quad_i ? OUT_W'(q_sum) : dbl_pack;
endmodule

// File: rtl/simd_sig_mul.sv
module simd_sig_mul #(
  parameter int LANES  = 4,   // quad mode needs exactly four lanes
  parameter int DBL_W  = 53,
  parameter int QUAD_W = 113
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         mode_i,
  input  logic [LANES*DBL_W-1:0]       a_i,
  input  logic [LANES*DBL_W-1:0]       b_i,
  output logic                         valid_o,
  output logic [LANES*2*DBL_W-1:0]     prod_o
);
  import simd_sig_mul_pkg::*;

  localparam int LANE_W = (QUAD_W + 1) / 2;
  localparam int OPND_W = LANES * DBL_W;
  localparam int OUT_W  = LANES * 2 * DBL_W;
  localparam int QP_W   = 2 * QUAD_W;

  mul_mode_e mode_in;
  assign mode_in = mul_mode_e'(mode_i);

  logic [LANES-1:0][LANE_W-1:0]   rt_a, rt_b;
  logic [LANES-1:0][LANE_W-1:0]   s1_a, s1_b;
  logic [LANES-1:0][2*LANE_W-1:0] s2_p;
  logic [OUT_W-1:0]               merged;
  logic s1_valid, s2_valid, s1_quad, s2_quad, s3_quad;

  sm_operand_route #(
    .LANES(LANES), .DBL_W(DBL_W), .QUAD_W(QUAD_W), .LANE_W(LANE_W), .OPND_W(OPND_W)
  ) route_i (
    .quad_i (mode_in == MODE_QUAD),
    .a_i    (a_i),
    .b_i    (b_i),
    .la_o   (rt_a),
    .lb_o   (rt_b)
  );

  // stage 1: routed operands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_quad  <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_quad <= (mode_in == MODE_QUAD);
        s1_a    <= rt_a;
        s1_b    <= rt_b;
      end
    end
  end

  // stage 2: lane products
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sm_lane_mul #(.DBL_W(DBL_W), .LANE_W(LANE_W)) mul_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (s1_valid),
      .dbl_i  (!s1_quad),
      .a_i    (s1_a[g]),
      .b_i    (s1_b[g]),
      .p_o    (s2_p[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_quad  <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_quad <= s1_quad;
    end
  end

  sm_prod_merge #(
    .LANES(LANES), .DBL_W(DBL_W), .QUAD_W(QUAD_W), .LANE_W(LANE_W), .OUT_W(OUT_W)
  ) merge_i (
    .quad_i (s2_quad),
    .p_i    (s2_p),
    .r_o    (merged)
  );

  // stage 3: output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      s3_quad <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= s2_valid;
      if (s2_valid) begin
        s3_quad <= s2_quad;
        prod_o  <= merged;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 3)); // R3

  AST_QUAD_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && s3_quad) |-> (prod_o[OUT_W-1:QP_W] == '0)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_valid |=> $stable(prod_o)); // R8
endmodule

// File: tb/simd_sig_mul_tb_top.sv
module simd_sig_mul_tb_top;
  localparam int LANES  = 4;
  localparam int DBL_W  = 53;
  localparam int QUAD_W = 113;
  localparam int OPND_W = LANES * DBL_W;
  localparam int OUT_W  = LANES * 2 * DBL_W;
  localparam int D_W    = 2 * DBL_W;
  localparam int QP_W   = 2 * QUAD_W;
  localparam int N      = 240;

  logic clk_i = 1'b0;
  logic rst_ni, valid_i, mode_i, valid_o;
  logic [OPND_W-1:0] a_i, b_i;
  logic [OUT_W-1:0]  prod_o;

  always #10 clk_i = ~clk_i;

  simd_sig_mul #(.LANES(LANES), .DBL_W(DBL_W), .QUAD_W(QUAD_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .prod_o(prod_o)
  );

  logic              hv [N];
  logic              hq [N];
  logic [OPND_W-1:0] ha [N];
  logic [OPND_W-1:0] hb [N];
  logic [OUT_W-1:0]  last_exp;
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [OPND_W-1:0] rnd_vec();
    logic [OPND_W-1:0] v = '0;
    for (int w = 0; w < 7; w++) v = (v << 32) | OPND_W'($urandom());
    return v;
  endfunction

  function automatic logic [OUT_W-1:0] model(input logic q, input logic [OPND_W-1:0] a, input logic [OPND_W-1:0] b);
    logic [OUT_W-1:0] r = '0;
    logic [QP_W-1:0]  qa, qb, qp;
    if (q) begin
      qa = QP_W'(a[QUAD_W-1:0]);
      qb = QP_W'(b[QUAD_W-1:0]);
      qp = qa * qb;
      r  = OUT_W'(qp);
    end else begin
      for (int k = 0; k < LANES; k++)
        r[k*D_W +: D_W] = D_W'(a[k*DBL_W +: DBL_W]) * D_W'(b[k*DBL_W +: DBL_W]);
    end
    return r;
  endfunction

  function automatic string tag_of(input int c, input logic v, input logic q);
    string s;
    if (!v) return "R8";
    s = q ? "R2" : "R1";
    if (q && c >= 60 && c < 120) s = {s, "/R5"};
    if (c >= 120 && c < 220) s = {s, "/R4"};
    if (c == 10 || c == 70 || c == 130 || c == 131) s = {s, "/R6"};
    if (c == 11 || c == 71 || c == 132 || c == 133) s = {s, "/R9"};
    return s;
  endfunction

  task automatic gen(input int c);
    logic v, q;
    logic [OPND_W-1:0] a, b;
    v = !(c % 11 == 5) && (c < 220);
    if (c < 60)       q = 1'b0;
    else if (c < 120) q = 1'b1;
    else              q = c[0];
    a = rnd_vec();
    b = rnd_vec();
    if (!q || c >= 120) begin
      // outside the R5 window keep quad upper bits clean
      if (q) begin a[OPND_W-1:QUAD_W] = '0; b[OPND_W-1:QUAD_W] = '0; end
    end
    if (c == 10 || c == 70 || c == 130 || c == 131) begin a = '1; b = '1; end
    if (c == 11 || c == 71 || c == 132 || c == 133) begin a = '0; end
    if (c == 71) b = '1;
    hv[c] = v; hq[c] = q; ha[c] = a; hb[c] = b;
    valid_i = v; mode_i = q; a_i = a; b_i = b;
  endtask

  task automatic check_entry(input int e);
    string t;
    logic [OUT_W-1:0] exp;
    t = tag_of(e, hv[e], hq[e]);
    chk(valid_o == hv[e], {"R3 valid ", t}, OUT_W'(valid_o), OUT_W'(hv[e]));
    if (hv[e]) begin
      exp = model(hq[e], ha[e], hb[e]);
      last_exp = exp;
    end else begin
      exp = last_exp;
    end
    chk(prod_o === exp, t, prod_o, exp);
  endtask

  initial begin
    last_exp = '0;
    rst_ni = 1'b0; valid_i = 1'b0; mode_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R7 valid", OUT_W'(valid_o), '0);
    chk(prod_o == '0, "R7 prod", prod_o, '0);
    rst_ni = 1'b1;
    for (int t = 0; t < N + 3; t++) begin
      @(negedge clk_i);
      if (t >= 3) check_entry(t - 3);
      if (t < N) gen(t);
      else valid_i = 1'b0;
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R3 act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule